// File: doc/BRIEF.md
# Multi-Mode Built-In Logic Block Observer Register

This block is a register of `WIDTH` flip-flops whose behaviour is chosen by a two-bit mode input. In system mode it works as an ordinary pipeline register and captures the parallel bus from the surrounding logic on every clock. In scan mode it becomes a serial shift chain, so test data can be shifted in and out. In clear mode it zeroes itself. In signature mode it becomes a multiple-input signature register, compacting one response word per clock.

The signature feedback comes from the parity of a set of taps chosen by the `TAP_MASK` parameter. This parity is folded into the lowest bit. Every higher bit folds its parallel input into its lower neighbour. If the parallel inputs are held at zero, the same hardware runs as a maximal-length pattern generator. A test controller, which is outside this block, sequences the modes. It typically seeds the register through scan or system mode, runs signature mode for a set number of clocks, and then reads the result through the parallel outputs or the scan output.

Top module: `bilbo_reg`

## Requirements
- R1: A synchronous active-high reset (`rst`=1 at a rising clock edge) sets `reg_q` to all zeros, and so `scan_out` to 0, on that edge.
- R2: With `mode_sel`=2'b11 (system), `reg_q` takes the value of `par_in` at the next rising edge.
- R3: With `mode_sel`=2'b10 (clear), `reg_q` becomes all zeros at the next rising edge, whatever the values of `par_in` and `scan_in`.
- R4: With `mode_sel`=2'b00 (scan), at each rising edge bit 0 loads `scan_in` and bit i (i>=1) loads the previous bit i-1. `par_in` has no effect in this mode.
- R5: `scan_out` always equals bit `WIDTH-1` of `reg_q`, in every mode.
- R6: With `mode_sel`=2'b01 (signature), each bit i>=1 loads `par_in[i]` XOR previous bit i-1 at the next edge.
- R7: With `mode_sel`=2'b01, bit 0 loads `par_in[0]` XOR the parity of (`reg_q` AND `TAP_MASK`). The default mask 8'hB8 taps bits 7, 5, 4 and 3 for `WIDTH`=8.
- R8: In signature mode with `par_in` held at zero, the default configuration started from a nonzero seed returns to that seed after exactly 255 clocks and not before.
- R9: Reset takes priority over every mode, so a reset during signature mode gives all zeros at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 00 scan, 01 signature, 10 clear, 11 system |
| par_in | input | WIDTH | Parallel data from the logic |
| scan_in | input | 1 | Serial scan input into bit 0 |
| reg_q | output | WIDTH | Register contents |
| scan_out | output | 1 | Serial scan output, bit WIDTH-1 |

## Verification
Every result is due exactly one rising edge after its mode and data are applied, because a single rank of flip-flops lies between the inputs and `reg_q`. `scan_out` follows `reg_q` with no further delay. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. Before that edge it advances its own arithmetic model by one step. The 255-step period check counts edges in the bench and compares the seed at every step.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  typedef enum logic [1:0] {
    MODE_SCAN   = 2'b00,
    MODE_SIG    = 2'b01,
    MODE_CLEAR  = 2'b10,
    MODE_SYSTEM = 2'b11
  } bilbo_mode_t;

  typedef struct packed {
    logic scan;
    logic sig;
    logic clear;
    logic system;
  } bilbo_sel_t;

endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
  import bilbo_pkg::*;
(
  input  logic [1:0] mode_sel,
  output bilbo_sel_t sel
);
  always_comb begin
    sel = '0;
    case (bilbo_mode_t'(mode_sel))
      MODE_SCAN:   sel.scan   = 1'b1;
      MODE_SIG:    sel.sig    = 1'b1;
      MODE_CLEAR:  sel.clear  = 1'b1;
      default:     sel.system = 1'b1;
    endcase
  end
endmodule

// File: rtl/bilbo_fb.sv
module bilbo_fb #(
  parameter int          WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  // Parity of the tapped bits forms the feedback term for bit 0.
  always_comb fb = ^(state & TAP_MASK);
endmodule

// File: rtl/bilbo_cell.sv
module bilbo_cell
  import bilbo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bilbo_sel_t sel,
  input  logic       d,
  input  logic       shift_src,
  input  logic       sig_src,
  output logic       q
);
  logic nxt;

  always_comb begin
    nxt = q;
    if (sel.system)     nxt = d;
    else if (sel.clear) nxt = 1'b0;
    else if (sel.scan)  nxt = shift_src;
    else if (sel.sig)   nxt = d ^ sig_src;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] reg_q,
  output logic             scan_out
);
  localparam int MSB = WIDTH - 1;

  bilbo_sel_t sel;
  logic       fb;

  bilbo_mode_dec u_dec (
    .mode_sel (mode_sel),
    .sel      (sel)
  );

  bilbo_fb #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .state (reg_q),
    .fb    (fb)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_head
      bilbo_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .d         (par_in[0]),
        .shift_src (scan_in),
        .sig_src   (fb),
        .q         (reg_q[0])
      );
    end else begin : g_body
      bilbo_cell u_cell (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .d         (par_in[i]),
        .shift_src (reg_q[i-1]),
        .sig_src   (reg_q[i-1]),
        .q         (reg_q[i])
      );
    end
  end

  assign scan_out = reg_q[MSB];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk
  import bilbo_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic [WIDTH-1:0] par_in,
  input logic             scan_in,
  input logic [WIDTH-1:0] reg_q,
  input logic             scan_out,
  input bilbo_sel_t       sel
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> reg_q == '0);

  p_system_load_r2: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b11 |=> reg_q == $past(par_in));

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b10 |=> reg_q == '0);

  p_scan_shift_r4: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b00 |=> reg_q == {$past(reg_q[WIDTH-2:0]), $past(scan_in)});

  p_scan_out_r5: assert property (@(posedge clk) disable iff (rst)
    scan_out == reg_q[WIDTH-1]);

  p_sig_upper_r6: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b01 |=>
      reg_q[WIDTH-1:1] == ($past(par_in[WIDTH-1:1]) ^ $past(reg_q[WIDTH-2:0])));

  p_sig_head_r7: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b01 |=> reg_q[0] == ($past(par_in[0]) ^ (^($past(reg_q) & TAP_MASK))));

  p_one_mode_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);
endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .par_in   (par_in),
  .scan_in  (scan_in),
  .reg_q    (reg_q),
  .scan_out (scan_out),
  .sel      (sel)
);

// File: tb/bilbo_reg_bench.sv
module bilbo_reg_bench;
  localparam int W = 8;
  localparam logic [W-1:0] MASK = 8'hB8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'b11;
  logic [W-1:0] par_in = '1;
  logic         scan_in = 1'b1;
  logic [W-1:0] reg_q;
  logic         scan_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [W-1:0] exp_q = '0;

  always #10 clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAP_MASK(MASK)) u_bilbo_reg (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .par_in(par_in),
    .scan_in(scan_in), .reg_q(reg_q), .scan_out(scan_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, advance the model, sample just after the rising edge.
  task automatic step(input logic r, input logic [1:0] m, input logic [W-1:0] d, input logic si);
    @(negedge clk);
    rst = r; mode_sel = m; par_in = d; scan_in = si;
    if (r) exp_q = '0;
    else case (m)
      2'b11: exp_q = d;
      2'b10: exp_q = '0;
      2'b00: exp_q = {exp_q[W-2:0], si};
      default: exp_q = d ^ {exp_q[W-2:0], ^(exp_q & MASK)};
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string req);
    check(req, reg_q, exp_q);
    check({req, "/R5"}, {7'd0, scan_out}, {7'd0, exp_q[W-1]});
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 / R9: reset held while system mode presents all ones
    step(1'b1, 2'b11, 8'hFF, 1'b1);
    step(1'b1, 2'b01, 8'hA5, 1'b1);
    check_all("R1");

    // R2, R6, R7, R4 swept over every register value
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 2'b11, v[7:0], 1'b0);
      check_all("R2");
      step(1'b0, 2'b01, v[7:0] ^ 8'h5A, 1'b0);
      check("R6", {reg_q[W-1:1], 1'b0}, {exp_q[W-1:1], 1'b0});
      check("R7", {7'd0, reg_q[0]}, {7'd0, exp_q[0]});
      step(1'b0, 2'b00, ~v[7:0], v[0]);
      check_all("R4");
      step(1'b0, 2'b10, 8'hFF, 1'b1);
      check_all("R3");
    end

    // R4: walking a pattern through the chain, par_in toggling and ignored
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 2'b00, (k % 2) ? 8'hFF : 8'h00, k[0] ^ k[2]);
      check_all("R4");
    end

    // R6/R7: long compaction run with varying responses
    for (int k = 0; k < 300; k++) begin
      step(1'b0, 2'b01, 8'((k * 37 + 11) ^ (k >> 3)), 1'b0);
      check_all("R7");
    end

    // R9: reset in the middle of signature mode
    step(1'b1, 2'b01, 8'hC3, 1'b1);
    check_all("R9");

    // R8: period of the pattern generator from seed 8'h01
    begin
      int early = 0;
      step(1'b0, 2'b11, 8'h01, 1'b0);
      check_all("R8");
      for (int k = 1; k <= 255; k++) begin
        step(1'b0, 2'b01, 8'h00, 1'b0);
        if (k < 255 && reg_q == 8'h01) early++;
      end
      check("R8", reg_q, 8'h01);
      check("R8", 8'(early), 8'h00);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule